// File: doc/BRIEF.md
# Phase Current Sample Receiver and Balancer

This block takes peak-current samples from a set of power stages, one single-wire serial line per phase, and turns them into data for current sharing. A stage starts converting when its phase PWM output falls, so a frame can arrive on any cycle. Each frame begins with a high start bit. Six data bits follow, most significant first, and every bit is held for two system clocks. The line rests low between frames.

One receiver per channel finds the start bit, re-times itself on it and takes each data bit in the second cycle of its two-cycle cell. It then gives out the word with a one-cycle strobe. A sample bank keeps the newest word of every channel and marks it as fresh. Once every enabled channel has a fresh word, the balancer works out the mean of the enabled samples, rounded down, and a signed deviation (sample minus mean) for each phase. It gives these out with a one-cycle update strobe and clears the fresh marks. Current-share control logic downstream uses the deviations to trim each phase.

Top module: `cur_sense_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it, every valid strobe is low and every data, mean and deviation output is zero.
- R2: If the start bit is first sampled high at clock edge E, `sample_valid_o` for that channel is high for exactly one cycle, from edge E+13. In that cycle the channel's slice of `sample_data_o` holds the six data bits, the first received in bit 5.
- R3: A data bit is taken from the second cycle of its two-cycle cell. A cell that is high in its first cycle and low in its second reads as 0, and it does not disturb the frame.
- R4: A line held low produces no strobe.
- R5: A start bit that is high for only one cycle is dropped, and no strobe follows.
- R6: When a data cell is low in its first cycle and high in its second, the partial word is dropped without a strobe, and that high cycle is taken as the start bit of a new frame.
- R7: The channels are received on their own. Frames on different lines that overlap in time give each channel its own correct word.
- R8: Two cycles after the strobe that completes a fresh sample on every channel enabled in `ch_active_i`, `avg_valid_o` pulses for one cycle. With it, `avg_o` gives floor(sum of the enabled samples / number of enabled channels).
- R9: Disabled channels are left out of the mean, and their deviation is zero. When no channel is enabled, no update takes place.
- R10: At each update, the deviation of each enabled channel i is the signed (DATA_W+1)-bit value sample_i minus mean, given in slice i of `err_o`.
- R11: An update clears all fresh marks. A later update needs a new sample from every enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_active_i | input | NUM_CH | Channels included in the mean |
| line_i | input | NUM_CH | Serial current line per channel, idles low |
| sample_valid_o | output | NUM_CH | One-cycle strobe per channel for a received word |
| sample_data_o | output | NUM_CH*DATA_W | Received word per channel, channel i in slice i |
| avg_valid_o | output | 1 | One-cycle strobe for a new mean and deviations |
| avg_o | output | DATA_W | Mean of enabled samples, rounded down |
| err_o | output | NUM_CH*(DATA_W+1) | Signed deviation per channel, sample minus mean |

## Verification
A received word is due 13 edges after the edge at which its start bit is first seen high. The mean and deviations that it completes are due two edges after that. The bench drives each line on the falling clock edge. A behavioural model is advanced on every rising edge from the line values it has just driven, and the design's outputs are compared with the model at the next falling edge, so every strobe is checked in the exact cycle it is due. Directed scenarios then count the strobes and check the known words, means and deviations after each stimulus has drained.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_t;
endpackage

// File: rtl/cs_frame_rx.sv
module cs_frame_rx
  import cs_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int LAST_T = 2 * DATA_W + 1;
  localparam int TW     = $clog2(LAST_T + 1);

  rx_state_t        state;
  logic [TW-1:0]    t;
  logic             half;
  logic [DATA_W-1:0] shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      t       <= '0;
      half    <= 1'b0;
      shift   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (line_i) begin
            state <= RX_BUSY;
            t     <= TW'(1);
            shift <= '0;
          end
        end
        default: begin
          if (t == TW'(1)) begin
            if (!line_i) state <= RX_IDLE;
            else         t     <= TW'(2);
          end else if (!t[0]) begin
            half <= line_i;
            t    <= t + TW'(1);
          end else if (!half && line_i) begin
            // rising edge inside a cell: a new conversion has begun
            t     <= TW'(1);
            shift <= '0;
          end else begin
            shift <= {shift[DATA_W-2:0], line_i};
            if (t == TW'(LAST_T)) begin
              valid_o <= 1'b1;
              data_o  <= {shift[DATA_W-2:0], line_i};
              state   <= RX_IDLE;
            end else begin
              t <= t + TW'(1);
            end
          end
        end
      endcase
    end
  end

  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_from_frame_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(state == RX_BUSY && t == TW'(LAST_T)));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && !line_i) |=> !valid_o);
  assert_glitch_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (state == RX_BUSY && t == TW'(1) && !line_i) |=> (state == RX_IDLE && !valid_o));
endmodule

// File: rtl/cs_sample_bank.sv
module cs_sample_bank #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        valid_i,
  input  logic [NUM_CH*DATA_W-1:0] data_i,
  input  logic                     clear_i,
  output logic [NUM_CH*DATA_W-1:0] samp_o,
  output logic [NUM_CH-1:0]        fresh_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        samp_o[i*DATA_W +: DATA_W] <= '0;
        fresh_o[i]                 <= 1'b0;
      end else begin
        if (valid_i[i]) begin
          samp_o[i*DATA_W +: DATA_W] <= data_i[i*DATA_W +: DATA_W];
          fresh_o[i]                 <= 1'b1;
        end else if (clear_i) begin
          fresh_o[i] <= 1'b0;
        end
      end
    end

    assert_fresh_set_R11: assert property (@(posedge clk) disable iff (rst)
      valid_i[i] |=> fresh_o[i]);
  end
endmodule

// File: rtl/cs_balance.sv
module cs_balance #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            act_i,
  input  logic [NUM_CH*DATA_W-1:0]     samp_i,
  input  logic [NUM_CH-1:0]            fresh_i,
  output logic                         clear_o,
  output logic                         avg_valid_o,
  output logic [DATA_W-1:0]            avg_o,
  output logic [NUM_CH*(DATA_W+1)-1:0] err_o
);
  localparam int CW = $clog2(NUM_CH + 1);
  localparam int SW = DATA_W + CW;

  logic [SW-1:0]     sum;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] mean;
  logic              update;

  always_comb begin
    sum = '0;
    cnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (act_i[i]) begin
        sum = sum + SW'(samp_i[i*DATA_W +: DATA_W]);
        cnt = cnt + CW'(1);
      end
    end
    mean = (cnt == '0) ? '0 : DATA_W'(sum / SW'(cnt));
  end

  assign update  = (act_i != '0) && ((fresh_i & act_i) == act_i);
  assign clear_o = update;

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_valid_o <= 1'b0;
      avg_o       <= '0;
    end else begin
      avg_valid_o <= update;
      if (update) avg_o <= mean;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_err
    logic signed [DATA_W:0] dev;
    assign dev = $signed({1'b0, samp_i[i*DATA_W +: DATA_W]}) - $signed({1'b0, mean});
    always_ff @(posedge clk) begin
      if (rst) begin
        err_o[i*(DATA_W+1) +: DATA_W+1] <= '0;
      end else if (update) begin
        err_o[i*(DATA_W+1) +: DATA_W+1] <= act_i[i] ? dev : '0;
      end
    end
  end

  assert_single_update_R11: assert property (@(posedge clk) disable iff (rst)
    avg_valid_o |=> !avg_valid_o);
  assert_needs_active_R9: assert property (@(posedge clk) disable iff (rst)
    avg_valid_o |-> ($past(act_i) != '0));
  assert_all_fresh_R8: assert property (@(posedge clk) disable iff (rst)
    avg_valid_o |-> (($past(fresh_i) & $past(act_i)) == $past(act_i)));
endmodule

// File: rtl/cur_sense_rx.sv
module cur_sense_rx #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            ch_active_i,
  input  logic [NUM_CH-1:0]            line_i,
  output logic [NUM_CH-1:0]            sample_valid_o,
  output logic [NUM_CH*DATA_W-1:0]     sample_data_o,
  output logic                         avg_valid_o,
  output logic [DATA_W-1:0]            avg_o,
  output logic [NUM_CH*(DATA_W+1)-1:0] err_o
);
  logic [NUM_CH*DATA_W-1:0] samp;
  logic [NUM_CH-1:0]        fresh;
  logic                     clear;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_rx
    cs_frame_rx #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .line_i  (line_i[i]),
      .valid_o (sample_valid_o[i]),
      .data_o  (sample_data_o[i*DATA_W +: DATA_W])
    );
  end

  cs_sample_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .valid_i (sample_valid_o),
    .data_i  (sample_data_o),
    .clear_i (clear),
    .samp_o  (samp),
    .fresh_o (fresh)
  );

  cs_balance #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bal (
    .clk         (clk),
    .rst         (rst),
    .act_i       (ch_active_i),
    .samp_i      (samp),
    .fresh_i     (fresh),
    .clear_o     (clear),
    .avg_valid_o (avg_valid_o),
    .avg_o       (avg_o),
    .err_o       (err_o)
  );

  assert_strobe_needs_reset_release_R1: assert property (@(posedge clk)
    $past(rst) |-> (sample_valid_o == '0 && !avg_valid_o));
endmodule

// File: tb/cur_sense_rx_tb.sv
module cur_sense_rx_tb;
  localparam int NCH = 6;
  localparam int DW  = 6;
  localparam int LIMIT = 100000;

  logic clk = 0;
  logic rst = 1;
  logic [NCH-1:0] act = '0;
  logic [NCH-1:0] line = '0;
  logic [NCH-1:0] s_valid;
  logic [NCH*DW-1:0] s_data;
  logic a_valid;
  logic [DW-1:0] a_avg;
  logic [NCH*(DW+1)-1:0] e_out;

  always #5 clk = ~clk;

  cur_sense_rx #(.NUM_CH(NCH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ch_active_i(act), .line_i(line),
    .sample_valid_o(s_valid), .sample_data_o(s_data),
    .avg_valid_o(a_valid), .avg_o(a_avg), .err_o(e_out));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit q[NCH][$];

  // observation counters for directed checks
  int o_vcnt[NCH];
  int o_data[NCH];
  int o_acnt;
  int o_avg;
  int o_err[NCH];

  // behavioural reference model
  int m_busy[NCH], m_t[NCH], m_half[NCH], m_shift[NCH];
  int m_v[NCH], m_d[NCH], m_s[NCH], m_f[NCH];
  int m_av, m_avg, m_err[NCH];

  task automatic check_eq(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int dut_err(int i);
    logic signed [DW:0] v;
    v = e_out[i*(DW+1) +: DW+1];
    return int'(v);
  endfunction

  // line driver: one queued bit per cycle, low when empty
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++)
      line[i] <= (q[i].size() > 0) ? q[i].pop_front() : 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=%0d expected below %0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_busy[i] = 0; m_t[i] = 0; m_half[i] = 0; m_shift[i] = 0;
        m_v[i] = 0; m_d[i] = 0; m_s[i] = 0; m_f[i] = 0; m_err[i] = 0;
      end
      m_av = 0; m_avg = 0;
    end else begin
      int sum, n, clr;
      bit all;
      // mean stage from previously stored samples
      sum = 0; n = 0; all = 1; clr = 0; m_av = 0;
      for (int i = 0; i < NCH; i++)
        if (act[i]) begin sum += m_s[i]; n++; if (!m_f[i]) all = 0; end
      if (n > 0 && all) begin
        m_av = 1; clr = 1; m_avg = sum / n;
        for (int i = 0; i < NCH; i++) m_err[i] = act[i] ? m_s[i] - m_avg : 0;
      end
      // storage stage
      for (int i = 0; i < NCH; i++) begin
        if (m_v[i]) begin m_s[i] = m_d[i]; m_f[i] = 1; end
        else if (clr) m_f[i] = 0;
      end
      // receivers
      for (int i = 0; i < NCH; i++) begin
        int b;
        b = line[i];
        m_v[i] = 0;
        if (!m_busy[i]) begin
          if (b) begin m_busy[i] = 1; m_t[i] = 1; m_shift[i] = 0; end
        end else if (m_t[i] == 1) begin
          if (!b) m_busy[i] = 0; else m_t[i] = 2;
        end else if (m_t[i] % 2 == 0) begin
          m_half[i] = b; m_t[i]++;
        end else if (!m_half[i] && b) begin
          m_t[i] = 1; m_shift[i] = 0;
        end else begin
          m_shift[i] = (m_shift[i] * 2 + b) % 64;
          if (m_t[i] == 13) begin m_v[i] = 1; m_d[i] = m_shift[i]; m_busy[i] = 0; end
          else m_t[i]++;
        end
      end
    end
  end

  // compare with the model and gather observations on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NCH; i++) begin
        check_eq($sformatf("R2 valid ch%0d cycle %0d", i, cyc), s_valid[i], m_v[i]);
        if (m_v[i]) check_eq($sformatf("R2 data ch%0d", i), s_data[i*DW +: DW], m_d[i]);
        if (s_valid[i]) begin o_vcnt[i]++; o_data[i] = s_data[i*DW +: DW]; end
      end
      check_eq($sformatf("R8 avg_valid cycle %0d", cyc), a_valid, m_av);
      if (m_av) begin
        check_eq("R8 avg", a_avg, m_avg);
        for (int i = 0; i < NCH; i++) check_eq($sformatf("R10 err ch%0d", i), dut_err(i), m_err[i]);
      end
      if (a_valid) begin
        o_acnt++; o_avg = a_avg;
        for (int i = 0; i < NCH; i++) o_err[i] = dut_err(i);
      end
    end
  end

  task automatic clear_obs();
    for (int i = 0; i < NCH; i++) begin o_vcnt[i] = 0; o_data[i] = -1; o_err[i] = -99; end
    o_acnt = 0; o_avg = -1;
  endtask

  task automatic do_reset(logic [NCH-1:0] a);
    @(negedge clk);
    rst = 1; act = a;
    repeat (3) @(negedge clk);
    check_eq("R1 valid in reset", int'(s_valid), 0);
    check_eq("R1 avg in reset", int'(a_avg), 0);
    check_eq("R1 err in reset", int'(e_out == '0), 1);
    rst = 0;
    @(negedge clk);
    check_eq("R1 after release avg_valid", a_valid, 0);
    clear_obs();
  endtask

  task automatic push_gap(int ch, int n);
    for (int k = 0; k < n; k++) q[ch].push_back(1'b0);
  endtask

  task automatic push_frame(int ch, int val);
    q[ch].push_back(1'b1); q[ch].push_back(1'b1);
    for (int b = DW - 1; b >= 0; b--) begin
      q[ch].push_back(val[b]); q[ch].push_back(val[b]);
    end
  endtask

  task automatic drain();
    bit busy;
    do begin
      @(negedge clk);
      busy = 0;
      for (int i = 0; i < NCH; i++) if (q[i].size() > 0) busy = 1;
    end while (busy);
    repeat (25) @(negedge clk);
  endtask

  initial begin
    clear_obs();
    // R7 / R8 / R10: all channels, staggered overlapping frames
    do_reset(6'h3F);
    for (int i = 0; i < NCH; i++) begin push_gap(i, i * 3); push_frame(i, (i + 1) * 10); end
    drain();
    for (int i = 0; i < NCH; i++) check_eq($sformatf("R7 count ch%0d", i), o_vcnt[i], 1);
    check_eq("R7 word ch3", o_data[3], 40);
    check_eq("R8 one update", o_acnt, 1);
    check_eq("R8 mean 35", o_avg, 35);
    check_eq("R10 err ch0", o_err[0], -25);
    check_eq("R10 err ch5", o_err[5], 25);

    // R2 bit order, R3 second-cycle sampling
    do_reset(6'h03);
    push_frame(1, 42);
    q[0].push_back(1'b1); q[0].push_back(1'b1);
    for (int b = 0; b < DW; b++) begin q[0].push_back(1'b1); q[0].push_back(1'b0); end
    drain();
    check_eq("R2 msb first 42", o_data[1], 42);
    check_eq("R3 high-low cells read 0", o_data[0], 0);
    check_eq("R3 frame kept", o_vcnt[0], 1);
    check_eq("R8 mean 21", o_avg, 21);

    // R4 idle line
    do_reset(6'h3F);
    repeat (60) @(negedge clk);
    check_eq("R4 no strobe on idle", o_vcnt[0] + o_vcnt[3], 0);

    // R5 one-cycle start glitch
    do_reset(6'h3F);
    q[2].push_back(1'b1); push_gap(2, 30);
    drain();
    check_eq("R5 glitch dropped", o_vcnt[2], 0);

    // R6 restart inside a frame
    do_reset(6'h3F);
    q[4].push_back(1); q[4].push_back(1); q[4].push_back(1); q[4].push_back(1);
    q[4].push_back(0); q[4].push_back(0); q[4].push_back(0);
    push_frame(4, 7);
    drain();
    check_eq("R6 single strobe", o_vcnt[4], 1);
    check_eq("R6 new word", o_data[4], 7);

    // R9 disabled channels excluded
    do_reset(6'h03);
    push_frame(0, 5); push_frame(1, 8); push_frame(2, 63);
    drain();
    check_eq("R9 mean 6", o_avg, 6);
    check_eq("R9 inactive err 0", o_err[2], 0);
    check_eq("R10 err ch1", o_err[1], 2);

    // R11 fresh marks cleared by an update
    do_reset(6'h03);
    push_frame(0, 4);
    drain();
    check_eq("R11 waits for ch1", o_acnt, 0);
    push_frame(1, 6);
    drain();
    check_eq("R11 update once", o_acnt, 1);
    check_eq("R11 mean 5", o_avg, 5);
    push_frame(0, 10);
    drain();
    check_eq("R11 stale ch1 not reused", o_acnt, 1);

    // R9 nothing enabled
    do_reset(6'h00);
    push_frame(0, 9);
    drain();
    check_eq("R9 no update when none active", o_acnt, 0);
    check_eq("R9 word still received", o_vcnt[0], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule